// File: doc/BRIEF.md
# Address-Masked GPIO Register Bank

This block is a general-purpose I/O bank of eight pins on a simple APB-style register bus. Each pin is set to input or output by one bit of a direction register. Each output pin drives its pad value and its output enable straight from the registers. Each input pin passes through a two-flop synchroniser before any read can see it.

The pin data is reached through an address window. In that window, address bits [9:2] act as a per-pin mask. A write changes only the pins that the address selects, and a read returns only those pins with zero elsewhere. Software can therefore set, clear or sample a single pin in one access, with no read-modify-write.

Every access completes in its access phase with no wait states. Any offset that is not decoded reads as zero and ignores writes.

Top module: `gpio_mask_bank`

## Requirements
- R1: After a synchronous active-low reset, all pins are inputs and the data register is zero, so `pad_oe` and `pad_out` are 0 and the direction register reads 0.
- R2: The direction register is at offset 0x400. Bit n set to 1 makes pin n an output and 0 makes it an input. It reads back as written, and `pad_oe[n]` equals direction bit n.
- R3: A write to the data window (offsets below 0x400, with bits [1:0] equal to 0) changes data bit n only when address bit n+2 is 1. Every other data bit keeps its value.
- R4: A read of the data window returns pin n's value in bit n when address bit n+2 is 1, and 0 in every bit whose address bit is 0.
- R5: The value of an input pin is read through a two-flop synchroniser. A pad change applied between two rising edges appears on `prdata` after the second rising edge that follows it.
- R6: A data write to a pin that is an input at the time of the write is not kept. `pad_out` equals the data register, so the value must be written again after the pin becomes an output.
- R7: A read of a pin configured as an output returns the value it drives, not the pad input.
- R8: The block ignores writes to any offset other than the direction register and the aligned data window, and reads of such offsets return 0. This covers offsets above 0x400 and offsets with address bits [1:0] not equal to 0.
- R9: A register changes only on an access phase (`psel`, `penable` and `pwrite` all 1). A setup phase alone has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Block select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data, valid during a selected read |
| pad_in | input | 8 | Asynchronous pad input values |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables, 1 = drive |

## Verification
The hardest situation to reach is a pin that receives a data write while it is still an input and is only later switched to output. A wrong design would keep the stale value and drive it as soon as the direction changes. The bench writes a 1 to an input pin and then turns that pin into an output. It checks that `pad_out` stays 0 until a second write arrives. The bench also holds a read open across a pad change to count the two synchroniser edges.

// File: rtl/gpio_mask_pkg.sv
// Package: shared types for the address-masked GPIO bank.
// Assumes the direction register sits just above the masked data window.
package gpio_mask_pkg;
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_DIR  = 2'd2
    } gpio_sel_e;
endpackage

// File: rtl/gpio_addr_decode.sv
// Module: decodes the bus address into a target register and a per-pin mask.
// Assumes ADDR_W > NPINS+2. The data window is every aligned offset below
// 1 << (NPINS+2). The direction register is at exactly that offset.
module gpio_addr_decode
    import gpio_mask_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int ADDR_W = 12
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output gpio_sel_e         sel,
    output logic [NPINS-1:0]  pin_mask,
    output logic              wr_dir,
    output logic              wr_data
);
    localparam int          MSK_LO  = 2;
    localparam int          MSK_HI  = NPINS + 1;
    localparam logic [ADDR_W-1:0] DIR_OFS = ADDR_W'(1) << (NPINS + 2);

    logic in_window;
    logic aligned;
    logic access_wr;

    // Classify the offset: data window, direction register or unmapped.
    always_comb begin
        aligned   = (paddr[1:0] == 2'b00);
        in_window = (paddr[ADDR_W-1:NPINS+2] == '0);
        if (in_window && aligned)
            sel = SEL_DATA;
        else if (paddr == DIR_OFS)
            sel = SEL_DIR;
        else
            sel = SEL_NONE;
    end

    // Extract the per-pin mask from the address bits above the byte lane.
    assign pin_mask  = paddr[MSK_HI:MSK_LO];

    // Form the write strobes, qualified by the access phase.
    assign access_wr = psel && penable && pwrite;
    assign wr_dir    = access_wr && (sel == SEL_DIR);
    assign wr_data   = access_wr && (sel == SEL_DATA);

    // At most one target is ever selected (R8).
    always_comb begin
        p_one_target_r8: assert ($onehot0({wr_dir, wr_data}))
            else $error("two register strobes at once");
    end
endmodule

// File: rtl/gpio_in_sync.sv
// Module: a multi-stage synchroniser for each pad input.
// Assumes the pads are asynchronous to clk. The reset value is 0.
module gpio_in_sync #(
    parameter int NPINS  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_sync
);
    logic [NPINS-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage captures the raw pad value.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= pad_in;
                end
            end else begin : g_next
                // Later stages shift the captured value along.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign pad_sync = chain[STAGES-1];
endmodule

// File: rtl/gpio_pin_regs.sv
// Module: holds the direction and data registers for the pins.
// Assumes the strobes are single-cycle. A data bit is written only when
// its mask bit is set and the pin is already an output.
module gpio_pin_regs #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_dir,
    input  logic             wr_data,
    input  logic [NPINS-1:0] pin_mask,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] dir_q,
    output logic [NPINS-1:0] data_q
);
    // Direction register: loaded whole on a direction write.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '0;
        else if (wr_dir) dir_q <= wdata;
    end

    genvar i;
    generate
        for (i = 0; i < NPINS; i++) begin : g_pin
            // Data bit: updated only when the pin is masked in and is an output.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    data_q[i] <= 1'b0;
                else if (wr_data && pin_mask[i] && dir_q[i])
                    data_q[i] <= wdata[i];
            end

            p_masked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_data && !pin_mask[i]) |=> $stable(data_q[i]))
                else $error("masked-out data bit changed");

            p_input_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (!dir_q[i]) |=> $stable(data_q[i]))
                else $error("data bit of an input pin changed");
        end
    endgenerate

    p_dir_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_dir) |=> $stable(dir_q))
        else $error("direction changed without a write");
endmodule

// File: rtl/gpio_mask_bank.sv
// Module: the top level of the address-masked GPIO bank.
// Assumes an APB-style bus with no wait states. prdata is combinational
// during a selected read and is 0 at all other times.
module gpio_mask_bank
    import gpio_mask_pkg::*;
#(
    parameter int NPINS       = 8,
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [NPINS-1:0]  pwdata,
    output logic [NPINS-1:0]  prdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe
);
    gpio_sel_e        sel;
    logic [NPINS-1:0] pin_mask;
    logic             wr_dir;
    logic             wr_data;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] data_q;
    logic [NPINS-1:0] pad_sync;
    logic [NPINS-1:0] pin_val;
    logic             rd_act;

    gpio_addr_decode #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_dec (
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .paddr    (paddr),
        .sel      (sel),
        .pin_mask (pin_mask),
        .wr_dir   (wr_dir),
        .wr_data  (wr_data)
    );

    gpio_pin_regs #(.NPINS(NPINS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_dir   (wr_dir),
        .wr_data  (wr_data),
        .pin_mask (pin_mask),
        .wdata    (pwdata),
        .dir_q    (dir_q),
        .data_q   (data_q)
    );

    gpio_in_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_in   (pad_in),
        .pad_sync (pad_sync)
    );

    // Pick the value of each pin: the driven bit for outputs, the synchronised pad for inputs.
    always_comb begin
        for (int n = 0; n < NPINS; n++)
            pin_val[n] = dir_q[n] ? data_q[n] : pad_sync[n];
    end

    // Read mux: masked pin values, the direction register, or zero.
    assign rd_act = psel && !pwrite;
    always_comb begin
        prdata = '0;
        if (rd_act) begin
            case (sel)
                SEL_DATA: prdata = pin_val & pin_mask;
                SEL_DIR:  prdata = dir_q;
                default:  prdata = '0;
            endcase
        end
    end

    // Drive the pads from the registers.
    assign pad_oe  = dir_q;
    assign pad_out = data_q;

    p_read_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && sel == SEL_DATA) |-> ((prdata & ~pin_mask) == '0))
        else $error("masked-out bit read as nonzero");

    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && sel == SEL_NONE) |-> (prdata == '0))
        else $error("unmapped read nonzero");

    p_setup_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!(psel && penable && pwrite)) |=> ($stable(pad_out) && $stable(pad_oe)))
        else $error("register changed outside an access phase");
endmodule

// File: tb/gpio_mask_bank_bench.sv
module gpio_mask_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [7:0]  pwdata = '0;
    logic [7:0]  prdata;
    logic [7:0]  pad_in = 8'hA5;
    logic [7:0]  pad_out, pad_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    gpio_mask_bank u_gpio_mask_bank (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // Vector fields: {is_write, addr[11:0], wdata[7:0], expected[7:0]}
    localparam int NV = 13;
    localparam logic [28:0] VEC [NV] = '{
        {1'b1, 12'h400, 8'h0F, 8'h00},  // pins 3..0 outputs
        {1'b1, 12'h3FC, 8'hFF, 8'h00},  // all-mask write, only outputs keep it
        {1'b0, 12'h3FC, 8'h00, 8'hAF},  // R4 R7: pads high nibble, driven low nibble
        {1'b0, 12'h004, 8'h00, 8'h01},  // R4: pin0 alone
        {1'b1, 12'h008, 8'h00, 8'h00},  // R3: clear pin1 alone
        {1'b0, 12'h03C, 8'h00, 8'h0D},  // R3 R7
        {1'b0, 12'h200, 8'h00, 8'h80},  // R4: pin7 input reads pad
        {1'b0, 12'h100, 8'h00, 8'h00},  // R4: pin6 input reads pad 0
        {1'b0, 12'h400, 8'h00, 8'h0F},  // R2
        {1'b1, 12'h800, 8'hFF, 8'h00},  // R8: unmapped write
        {1'b0, 12'h800, 8'h00, 8'h00},  // R8: unmapped read
        {1'b1, 12'h03E, 8'h00, 8'h00},  // R8: misaligned write
        {1'b0, 12'h03C, 8'h00, 8'h0D}   // R8: data untouched
    };

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk); penable = 1; #1 d = prdata;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset state
        #1 check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 pad_out", pad_out, 8'h00);
        bus_read(12'h400, rd); check("R1 dir", rd, 8'h00);
        bus_read(12'h3FC, rd); check("R1 inputs read pads", rd, 8'hA5);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            if (VEC[v][28]) bus_write(VEC[v][27:16], VEC[v][15:8]);
            else begin
                bus_read(VEC[v][27:16], rd);
                check($sformatf("vec %0d (R2 R3 R4 R7 R8)", v), rd, VEC[v][7:0]);
            end
        end
        check("R2 pad_oe follows dir", pad_oe, 8'h0F);
        check("R6 pad_out equals data", pad_out, 8'h0D);

        // R9: setup phase only
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = 12'h3FC; pwdata = 8'h00;
        @(negedge clk); psel = 0; pwrite = 0;
        #1 check("R9 setup only", pad_out, 8'h0D);

        // R6: write to input pin is lost
        bus_write(12'h200, 8'h80);
        check("R6 input write not driven", pad_out, 8'h0D);
        bus_write(12'h400, 8'h8F);
        check("R2 pin7 enabled", pad_oe, 8'h8F);
        check("R6 stale value not kept", pad_out, 8'h0D);
        bus_write(12'h200, 8'h80);
        check("R6 rewrite drives", pad_out, 8'h8D);
        pad_in = 8'h25;  // pad bit7 low, output must still read 1
        repeat (3) @(posedge clk);
        bus_read(12'h200, rd); check("R7 output reads driven", rd, 8'h80);

        // R5: synchroniser latency on pin4 (input, pad currently 0)
        @(negedge clk); psel = 1; penable = 1; pwrite = 0; paddr = 12'h040; pad_in = 8'h35;
        #1 check("R5 before edges", prdata, 8'h00);
        @(negedge clk); #1 check("R5 after one edge", prdata, 8'h00);
        @(negedge clk); #1 check("R5 after two edges", prdata, 8'h10);
        psel = 0; penable = 0;

        finish_run();
    end
endmodule